// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a memory-mapped watchdog built around a down-counter. Software loads a count, sets an optional early-warning threshold and starts the countdown. While the timer runs, the count drops by one on every clock. When the running count meets the threshold, an early-warning interrupt rises. When it reaches zero, a timeout interrupt rises and the counter stays at zero. Software keeps the system alive by reloading the count before it runs out.

The count, threshold and enable registers are protected against stray writes. A write to any of them is accepted only when the bus write just before it placed a fixed 32-bit key, `0xF1D0DEAD`, in the unlock register. Every other write locks the block again. Reads never need the key.

Each interrupt is backed by a sticky status bit. Those bits can be cleared only through a separate privileged clear port, never through the register bus.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset the enable is 0, the count is 0, the threshold is 0, the block is locked, both status bits are 0 and both interrupt outputs are low.
- R2: A write to offset 0x0 (count), 0x4 (threshold) or 0x8 (enable, bit 0) takes effect only if the immediately preceding bus write put 0xF1D0DEAD at offset 0xC. Reads in between do not disturb the key. A locked write, or a write to an address whose two low bits are not zero, changes nothing.
- R3: Any bus write other than the key write to 0xC leaves the block locked afterwards. This includes a wrong value written to 0xC and the protected write that the key allowed. So a second protected write after a single key write is ignored.
- R4: With enable bit 0 at 1, the count falls by one on each clock. With enable at 0, the count holds its value. A keyed write to 0x0 loads the count. A read of 0x0 returns the current count.
- R5: When the timer is enabled and the count is 0, status bit 9 (timeout) sets, and the count stays at 0.
- R6: When the timer is enabled and the count equals a non-zero threshold, status bit 8 (early warning) sets. A threshold of 0 never sets it.
- R7: A status bit stays set, even across a reload of the count, until a clear-port cycle has the matching bit (8 or 9) set in its mask. Clearing one bit leaves the other bit unchanged.
- R8: `irq_thresh` equals status bit 8 and `irq_timeout` equals status bit 9. A read of 0xC returns the status word: bit 9 is timeout, bit 8 is early warning, bit 0 is 1 while the key is armed, and all other bits are 0. A read of 0x4 returns the threshold, and a read of 0x8 returns the enable in bit 0.
- R9: Read data appears on `bus_rdata` on the clock after `bus_rd` is sampled, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| clr_valid | input | 1 | Privileged clear strobe |
| clr_mask | input | DATA_W | Clear mask: bit 8 clears early warning, bit 9 clears timeout |
| irq_thresh | output | 1 | Early-warning interrupt level |
| irq_timeout | output | 1 | Timeout interrupt level |

## Verification
The bench builds the block with its default parameters: a 32-bit count, a 32-bit data bus and a 4-bit address. With these defaults the real key value can be used, and the count can be loaded close to 0xFFFFFFFF to show that the top bits count down correctly. Short loads of 1 to 20 clocks reach the threshold and zero crossings quickly, so every status path is covered within a few hundred cycles.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  // Status word bit positions, decoded by the interrupt clear path.
  localparam int unsigned THR_BIT = 8;
  localparam int unsigned TO_BIT  = 9;
  localparam int unsigned ARM_BIT = 0;

  // Word index (address bits 3:2) of each register.
  localparam logic [1:0] IDX_COUNT  = 2'd0;
  localparam logic [1:0] IDX_THRESH = 2'd1;
  localparam logic [1:0] IDX_ENABLE = 2'd2;
  localparam logic [1:0] IDX_UNLOCK = 2'd3;

  localparam logic [31:0] UNLOCK_KEY = 32'hF1D0_DEAD;
endpackage

// File: rtl/kwd_keygate.sv
module kwd_keygate
  import kwd_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              armed,
  output logic              wr_count,
  output logic              wr_thresh,
  output logic              wr_enable
);
  logic       aligned;
  logic [1:0] idx;
  logic       key_write;
  logic       accept;
  logic       armed_q;

  // Only aligned word addresses in the 16-byte window decode.
  assign aligned   = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
  assign idx       = bus_addr[3:2];
  assign key_write = bus_wr && aligned && (idx == IDX_UNLOCK) && (bus_wdata == KEY);

  // One arm flag: every write re-evaluates it, so only a key write leaves it set.
  always_ff @(posedge clk) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (bus_wr) armed_q <= key_write;
  end

  assign armed     = armed_q;
  assign accept    = bus_wr && aligned && armed_q;
  assign wr_count  = accept && (idx == IDX_COUNT);
  assign wr_thresh = accept && (idx == IDX_THRESH);
  assign wr_enable = accept && (idx == IDX_ENABLE);

  // R3: after any write other than a key write, the block is locked.
  a_r3_relock_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !(aligned && idx == IDX_UNLOCK && bus_wdata == KEY)) |=> !armed);

  // R2: a key write arms the gate for the next cycle.
  a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && aligned && idx == IDX_UNLOCK && bus_wdata == KEY) |=> armed);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             thr_load,
  input  logic [CNT_W-1:0] thr_val,
  input  logic             en_load,
  input  logic             en_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] thr,
  output logic             en,
  output logic             thr_evt,
  output logic             to_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr_q;
  logic             en_q;

  // One countdown step: the count falls while running and saturates at zero.
  function automatic logic [CNT_W-1:0] count_step(logic [CNT_W-1:0] cur, logic run);
    if (run && (cur != '0)) return cur - 1'b1;
    return cur;
  endfunction

  // Early warning fires only for a non-zero threshold that the running count meets.
  function automatic logic thresh_match(logic [CNT_W-1:0] cur, logic [CNT_W-1:0] lim, logic run);
    return run && (lim != '0) && (cur == lim);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      thr_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_load ? cnt_val : count_step(cnt_q, en_q);
      if (thr_load) thr_q <= thr_val;
      if (en_load)  en_q  <= en_val;
    end
  end

  assign cnt     = cnt_q;
  assign thr     = thr_q;
  assign en      = en_q;
  assign thr_evt = thresh_match(cnt_q, thr_q, en_q);
  assign to_evt  = en_q && (cnt_q == '0);

  // R4: a stopped counter holds its value.
  a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_load) |=> (cnt == $past(cnt)));

  // R4: a running, non-zero counter falls by exactly one.
  a_r4_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_load && cnt != '0) |=> (cnt + 1'b1 == $past(cnt)));

  // R5: a running counter at zero stays at zero.
  a_r5_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/kwd_status.sv
module kwd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_thr,
  input  logic set_to,
  input  logic clr_thr,
  input  logic clr_to,
  output logic sts_thr,
  output logic sts_to
);
  logic thr_q;
  logic to_q;

  // A set in the same cycle as a clear wins, so no event is lost.
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set || (cur && !clr);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      thr_q <= sticky_next(thr_q, set_thr, clr_thr);
      to_q  <= sticky_next(to_q,  set_to,  clr_to);
    end
  end

  assign sts_thr = thr_q;
  assign sts_to  = to_q;

  // R7: a set status bit survives until its clear arrives.
  a_r7_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_to && !clr_to) |=> sts_to);
  a_r7_thresh_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_thr && !clr_thr) |=> sts_thr);

  // R6/R5: events always reach their status bits.
  a_r6_thresh_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_thr |=> sts_thr);
  a_r5_timeout_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_to |=> sts_to);
endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
  import kwd_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              clr_valid,
  input  logic [DATA_W-1:0] clr_mask,
  output logic              irq_thresh,
  output logic              irq_timeout
);
  logic             armed;
  logic             wr_count;
  logic             wr_thresh;
  logic             wr_enable;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] thr;
  logic             en;
  logic             thr_evt;
  logic             to_evt;
  logic             sts_thr;
  logic             sts_to;
  logic             clr_thr;
  logic             clr_to;
  logic [DATA_W-1:0] cnt_ext;
  logic [DATA_W-1:0] thr_ext;
  logic [DATA_W-1:0] rdata_q;
  logic              rd_aligned;
  logic              unused_clr_bits;

  kwd_keygate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .armed     (armed),
    .wr_count  (wr_count),
    .wr_thresh (wr_thresh),
    .wr_enable (wr_enable)
  );

  kwd_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_load (wr_count),
    .cnt_val  (bus_wdata[CNT_W-1:0]),
    .thr_load (wr_thresh),
    .thr_val  (bus_wdata[CNT_W-1:0]),
    .en_load  (wr_enable),
    .en_val   (bus_wdata[0]),
    .cnt      (cnt),
    .thr      (thr),
    .en       (en),
    .thr_evt  (thr_evt),
    .to_evt   (to_evt)
  );

  assign clr_thr = clr_valid && clr_mask[THR_BIT];
  assign clr_to  = clr_valid && clr_mask[TO_BIT];
  assign unused_clr_bits = ^clr_mask;

  kwd_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_thr (thr_evt),
    .set_to  (to_evt),
    .clr_thr (clr_thr),
    .clr_to  (clr_to),
    .sts_thr (sts_thr),
    .sts_to  (sts_to)
  );

  // Widen the count and the threshold onto the data bus; which variant is built depends on the widths.
  generate
    if (CNT_W == DATA_W) begin : g_same_w
      assign cnt_ext = cnt;
      assign thr_ext = thr;
    end else begin : g_zero_ext
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt};
      assign thr_ext = {{(DATA_W-CNT_W){1'b0}}, thr};
    end
  endgenerate

  function automatic logic [DATA_W-1:0] status_word(logic s_thr, logic s_to, logic s_arm);
    logic [DATA_W-1:0] w;
    w          = '0;
    w[THR_BIT] = s_thr;
    w[TO_BIT]  = s_to;
    w[ARM_BIT] = s_arm;
    return w;
  endfunction

  assign rd_aligned = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      if (!rd_aligned) rdata_q <= '0;
      else begin
        case (bus_addr[3:2])
          IDX_COUNT:  rdata_q <= cnt_ext;
          IDX_THRESH: rdata_q <= thr_ext;
          IDX_ENABLE: rdata_q <= {{(DATA_W-1){1'b0}}, en};
          default:    rdata_q <= status_word(sts_thr, sts_to, armed);
        endcase
      end
    end
  end

  assign bus_rdata   = rdata_q;
  assign irq_thresh  = sts_thr;
  assign irq_timeout = sts_to;

  // R2: while locked, no write can move the threshold or the enable.
  a_r2_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !armed) |=> ($stable(thr) && $stable(en)));

  // R2: a locked write to the count never loads it.
  a_r2_locked_count: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !armed && !en) |=> (cnt == $past(cnt)));

  // R9: read data changes only after a sampled read.
  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/keyguard_wdt_test.sv
module keyguard_wdt_test;
  localparam logic [31:0] KEYV = 32'hF1D0_DEAD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        clr_valid = 1'b0;
  logic [31:0] clr_mask = '0;
  logic        irq_thresh;
  logic        irq_timeout;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  keyguard_wdt uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clr_valid(clr_valid), .clr_mask(clr_mask),
    .irq_thresh(irq_thresh), .irq_timeout(irq_timeout)
  );

  typedef struct packed {
    logic [31:0] load;
    logic [31:0] thr;
    logic [15:0] run;
    logic [31:0] exp_cnt;
    logic        exp_thr;
    logic        exp_to;
  } vec_t;

  // Run: enable, wait run cycles, then a keyed disable (2 more edges of counting).
  localparam vec_t VECS [0:6] = '{
    '{32'd20,         32'd10,         16'd5,  32'd13,         1'b0, 1'b0},
    '{32'd20,         32'd16,         16'd5,  32'd13,         1'b1, 1'b0},
    '{32'd5,          32'd3,          16'd10, 32'd0,          1'b1, 1'b1},
    '{32'd8,          32'd0,          16'd10, 32'd0,          1'b0, 1'b1},
    '{32'd1,          32'd1,          16'd0,  32'd0,          1'b1, 1'b1},
    '{32'd100,        32'd50,         16'd40, 32'd58,         1'b0, 1'b0},
    '{32'hFFFF_FFFF,  32'hFFFF_FFF0,  16'd20, 32'hFFFF_FFE9,  1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge; each takes one rising edge.
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic kwr(input logic [3:0] a, input logic [31:0] d);
    wr(4'hC, KEYV);
    wr(a, d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic clr(input logic [31:0] m);
    clr_valid = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_valid = 1'b0; clr_mask = '0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(4'h0, v); check("R1 count", v, 32'd0);
    rd(4'h4, v); check("R1 threshold", v, 32'd0);
    rd(4'h8, v); check("R1 enable", v, 32'd0);
    rd(4'hC, v); check("R1 status/lock", v, 32'd0);
    check("R1 irqs", {30'd0, irq_timeout, irq_thresh}, 32'd0);

    // R4 R5 R6 R8: vector table
    foreach (VECS[i]) begin
      clr(32'h300);
      kwr(4'h0, VECS[i].load);
      kwr(4'h4, VECS[i].thr);
      kwr(4'h8, 32'd1);
      repeat (VECS[i].run) @(negedge clk);
      kwr(4'h8, 32'd0);
      rd(4'h0, v);
      check($sformatf("R4 vec%0d count", i), v, VECS[i].exp_cnt);
      rd(4'hC, v);
      check($sformatf("R5/R6 vec%0d status", i), v & 32'h300,
            {22'd0, VECS[i].exp_to, VECS[i].exp_thr, 8'd0});
      check($sformatf("R8 vec%0d irq pins", i), {30'd0, irq_timeout, irq_thresh},
            {30'd0, VECS[i].exp_to, VECS[i].exp_thr});
    end
    clr(32'h300);

    // R2: unkeyed write ignored
    wr(4'h0, 32'd77);
    rd(4'h0, v); check("R2 unkeyed count write", v, 32'hFFFF_FFE9);

    // R3: wrong key leaves block locked
    wr(4'hC, 32'h1234_5678);
    rd(4'hC, v); check("R3 wrong key not armed", v, 32'd0);
    wr(4'h0, 32'd77);
    rd(4'h0, v); check("R3 wrong key count write", v, 32'hFFFF_FFE9);

    // R2 R8: key arms, a read in between does not disturb it
    wr(4'hC, KEYV);
    rd(4'hC, v); check("R8 armed bit", v, 32'd1);
    wr(4'h0, 32'd55);
    rd(4'h0, v); check("R2 keyed write after read", v, 32'd55);

    // R3: second write after one key ignored
    wr(4'h0, 32'd88);
    rd(4'h0, v); check("R3 second write", v, 32'd55);
    kwr(4'h4, 32'd9);
    wr(4'h0, 32'd99);
    rd(4'h0, v); check("R3 relock after accepted write", v, 32'd55);
    rd(4'h4, v); check("R8 threshold readback", v, 32'd9);

    // R2: misaligned address decodes nothing
    kwr(4'h1, 32'd33);
    rd(4'h0, v); check("R2 misaligned write", v, 32'd55);

    // R4: stopped counter holds
    rd(4'h0, v);
    repeat (5) @(negedge clk);
    rd(4'h0, v2); check("R4 stopped holds", v2, v);

    // R5: running counter stays at zero
    kwr(4'h0, 32'd3);
    kwr(4'h8, 32'd1);
    repeat (10) @(negedge clk);
    rd(4'h0, v); check("R5 stays at zero", v, 32'd0);
    rd(4'h8, v); check("R4 enable readback", v, 32'd1);
    rd(4'hC, v); check("R5 timeout status", v & 32'h300, 32'h200);

    // R7: reload keeps status; clearing one bit leaves the other
    kwr(4'h0, 32'd100);
    rd(4'hC, v); check("R7 survives reload", v & 32'h300, 32'h200);
    clr(32'h100);
    rd(4'hC, v); check("R7 other-bit clear", v & 32'h300, 32'h200);
    check("R8 irq_timeout held", {31'd0, irq_timeout}, 32'd1);
    clr(32'h200);
    rd(4'hC, v); check("R7 cleared", v & 32'h300, 32'h000);
    check("R8 irqs low", {30'd0, irq_timeout, irq_thresh}, 32'd0);
    kwr(4'h8, 32'd0);

    // R9: read data holds without a read
    rd(4'h4, v);
    repeat (3) @(negedge clk);
    check("R9 rdata holds", bus_rdata, 32'd9);

    finish_run();
  end
endmodule